// File: doc/BRIEF.md
# Oversampling UART Receiver

This block turns an asynchronous serial line into received characters. It watches the line on a free-running enable that pulses sixteen times per bit period. It accepts a start bit only when the line is still low near the middle of that bit. It then takes each data bit at the centre of its period, least significant bit first, and checks an optional parity bit and the first stop bit. Each finished character goes into a single receive buffer, together with a data-ready flag and parity, framing and overrun flags.

Frame settings come from four configuration inputs: word length, parity enable, even/odd select and stick parity. They are captured when a start bit is detected, so a change made during a frame takes effect with the next character. A one-cycle read strobe consumes the buffered character.

Top module: `uart_rx_core`

## Requirements
- R1: The word length follows `cfg_wlen`: 00 gives 5 data bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first and each one is sampled at the centre of its bit period. State only advances on cycles where `tick16` is high.
- R2: For words shorter than 8 bits, the upper bits of `rx_data` above the word length read as 0.
- R3: `data_ready` goes to 1 the cycle after a complete character is stored and returns to 0 after a cycle with `rd_strobe` high and no new character.
- R4: A start is valid only if the line, after its falling edge, is still low on the 8th tick counting the detection tick. If the line is high then, the start is dropped, nothing is stored and `data_ready` stays 0.
- R5: With `cfg_par_en` = 0 the frame has no parity bit and `parity_err` is 0 for every stored character.
- R6: With parity enabled and `cfg_par_stick` = 0, `cfg_par_even` = 1 selects even parity and 0 selects odd parity. A mismatch sets `parity_err` with the character.
- R7: With parity enabled and `cfg_par_stick` = 1, the parity bit must be 1 when `cfg_par_even` = 0 and 0 when `cfg_par_even` = 1. Any other value sets `parity_err`.
- R8: A 0 sampled where the first stop bit belongs sets `framing_err`. The character is still stored and `data_ready` is still set.
- R9: When a character completes while `data_ready` is still 1, `overrun_err` is set and `rx_data` takes the new character.
- R10: `parity_err` and `framing_err` describe the character currently in the buffer and are replaced on every store. A read strobe clears them together with `overrun_err`.
- R11: After reset, `rx_data` is 0 and `data_ready`, `parity_err`, `framing_err` and `overrun_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| cfg_wlen | input | 2 | Word length select (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | Even parity select, or stick level select |
| cfg_par_stick | input | 1 | Stick parity mode |
| rd_strobe | input | 1 | Consume the buffered character |
| rx_data | output | 8 | Receive buffer, zero-filled above the word length |
| data_ready | output | 1 | Buffer holds an unread character |
| parity_err | output | 1 | Parity mismatch on the buffered character |
| framing_err | output | 1 | Stop bit of the buffered character was 0 |
| overrun_err | output | 1 | A character was overwritten before being read |

## Verification
On every cycle, the assertions check the following. The sampler holds its state between ticks. A store always raises data ready. A store onto an unread character raises overrun. A lone read strobe clears the flags. A stored word never has bits set above its length, and never reports a parity error when parity is off. The bench scenarios cover everything that depends on serial timing. This includes the bit order, the sampling point for each word length, the odd, even and stick parity outcomes, the glitch rejection, and a framing error that still stores its character. The bench also checks that the buffer contents after an overrun are the later character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int unsigned RX_MAX_BITS = 8;
    localparam int unsigned RX_MIN_BITS = 5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic [1:0] wlen;
    } rx_cfg_t;

    typedef struct packed {
        logic [RX_MAX_BITS-1:0] data;
        logic                   perr;
        logic                   ferr;
    } rx_char_t;

    function automatic int unsigned word_bits(input logic [1:0] wlen);
        return RX_MIN_BITS + int'(wlen);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rx_s,
    input  rx_cfg_t  cfg_i,
    output logic     load_o,
    output rx_char_t chr_o
);

    localparam int unsigned CNT_W     = $clog2(OVERSAMPLE);
    localparam int unsigned IDX_W     = $clog2(RX_MAX_BITS);
    localparam int unsigned START_MID = OVERSAMPLE / 2 - 2;
    localparam int unsigned CNT_LAST  = OVERSAMPLE - 1;

    typedef struct packed {
        rx_state_e              st;
        logic [CNT_W-1:0]       cnt;
        logic [IDX_W-1:0]       idx;
        logic                   prev;
        logic [RX_MAX_BITS-1:0] shreg;
        logic                   par_acc;
        logic                   perr_pend;
        rx_cfg_t                cfg;
        logic                   load;
        rx_char_t               chr;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   at_centre;
    logic   last_bit;
    logic   exp_par;

    always_comb begin
        at_centre = (fr_q.cnt == CNT_W'(CNT_LAST));
        last_bit  = (fr_q.idx == IDX_W'(word_bits(fr_q.cfg.wlen) - 1));
        if (fr_q.cfg.stick) exp_par = ~fr_q.cfg.even;
        else if (fr_q.cfg.even) exp_par = fr_q.par_acc;
        else exp_par = ~fr_q.par_acc;
    end

    always_comb begin
        fr_d      = fr_q;
        fr_d.load = 1'b0;
        if (tick) begin
            case (fr_q.st)
                RX_IDLE: begin
                    fr_d.prev = rx_s;
                    if (fr_q.prev && !rx_s) begin
                        fr_d.st        = RX_START;
                        fr_d.cnt       = '0;
                        fr_d.idx       = '0;
                        fr_d.shreg     = '0;
                        fr_d.par_acc   = 1'b0;
                        fr_d.perr_pend = 1'b0;
                        fr_d.cfg       = cfg_i;
                    end
                end
                RX_START: begin
                    if (fr_q.cnt == CNT_W'(START_MID)) begin
                        fr_d.cnt = '0;
                        if (rx_s) begin
                            fr_d.st   = RX_IDLE;
                            fr_d.prev = 1'b1;
                        end else begin
                            fr_d.st = RX_DATA;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (at_centre) begin
                        fr_d.cnt              = '0;
                        fr_d.shreg[fr_q.idx]  = rx_s;
                        fr_d.par_acc          = fr_q.par_acc ^ rx_s;
                        if (last_bit) fr_d.st = fr_q.cfg.par_en ? RX_PAR : RX_STOP;
                        else          fr_d.idx = fr_q.idx + 1'b1;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (at_centre) begin
                        fr_d.cnt       = '0;
                        fr_d.perr_pend = (rx_s != exp_par);
                        fr_d.st        = RX_STOP;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_centre) begin
                        fr_d.cnt      = '0;
                        fr_d.st       = RX_IDLE;
                        fr_d.prev     = rx_s;
                        fr_d.load     = 1'b1;
                        fr_d.chr.data = fr_q.shreg;
                        fr_d.chr.perr = fr_q.perr_pend;
                        fr_d.chr.ferr = ~rx_s;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                default: fr_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q    <= '0;
            fr_q.st <= RX_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign load_o = fr_q.load;
    assign chr_o  = fr_q.chr;

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(fr_q.st)); // R1

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> ((chr_o.data >> word_bits(fr_q.cfg.wlen)) == '0)); // R2

    AST_NO_PERR_WITHOUT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !fr_q.cfg.par_en) |-> !chr_o.perr); // R5

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  rx_char_t               chr_i,
    input  logic                   rd_i,
    output logic [RX_MAX_BITS-1:0] data_o,
    output logic                   ready_o,
    output logic                   perr_o,
    output logic                   ferr_o,
    output logic                   ovr_o
);

    typedef struct packed {
        logic [RX_MAX_BITS-1:0] data;
        logic                   ready;
        logic                   perr;
        logic                   ferr;
        logic                   ovr;
    } buf_t;

    buf_t bf_d, bf_q;

    always_comb begin
        bf_d = bf_q;
        if (rd_i) begin
            bf_d.ready = 1'b0;
            bf_d.perr  = 1'b0;
            bf_d.ferr  = 1'b0;
            bf_d.ovr   = 1'b0;
        end
        if (load_i) begin
            bf_d.data  = chr_i.data;
            bf_d.ready = 1'b1;
            bf_d.perr  = chr_i.perr;
            bf_d.ferr  = chr_i.ferr;
            bf_d.ovr   = bf_q.ovr | (bf_q.ready & ~rd_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bf_q <= '0;
        else        bf_q <= bf_d;
    end

    assign data_o  = bf_q.data;
    assign ready_o = bf_q.ready;
    assign perr_o  = bf_q.perr;
    assign ferr_o  = bf_q.ferr;
    assign ovr_o   = bf_q.ovr;

    AST_STORE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ready_o); // R3

    AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i) |=> (!ready_o && !ovr_o && !perr_o && !ferr_o)); // R10

    AST_OVERRUN_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ready_o && !rd_i) |=> (ovr_o && ready_o)); // R9

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_line,
    input  logic                   tick16,
    input  logic [1:0]             cfg_wlen,
    input  logic                   cfg_par_en,
    input  logic                   cfg_par_even,
    input  logic                   cfg_par_stick,
    input  logic                   rd_strobe,
    output logic [RX_MAX_BITS-1:0] rx_data,
    output logic                   data_ready,
    output logic                   parity_err,
    output logic                   framing_err,
    output logic                   overrun_err
);

    logic     rx_s;
    logic     load;
    rx_char_t chr;
    rx_cfg_t  cfg;

    assign cfg = '{stick: cfg_par_stick, even: cfg_par_even,
                   par_en: cfg_par_en, wlen: cfg_wlen};

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    uart_rx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .rx_s  (rx_s),
        .cfg_i (cfg),
        .load_o(load),
        .chr_o (chr)
    );

    uart_rx_buffer u_buffer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .chr_i  (chr),
        .rd_i   (rd_strobe),
        .data_o (rx_data),
        .ready_o(data_ready),
        .perr_o (parity_err),
        .ferr_o (framing_err),
        .ovr_o  (overrun_err)
    );

endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;

    typedef struct {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] div_q = 2'd0;
    logic       tick16;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       mon_rd = 1'b0;
    logic       man_rd = 1'b0;
    logic       rd_strobe;
    logic [7:0] rx_data;
    logic       data_ready, parity_err, framing_err, overrun_err;
    logic       mon_en = 1'b1;

    int total = 0;
    int bad = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) div_q <= div_q + 2'd1;
    assign tick16    = (div_q == 2'd0);
    assign rd_strobe = mon_rd | man_rd;

    uart_rx_core u_uart_rx_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_line      (rx_line),
        .tick16       (tick16),
        .cfg_wlen     (cfg_wlen),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .cfg_par_stick(cfg_par_stick),
        .rd_strobe    (rd_strobe),
        .rx_data      (rx_data),
        .data_ready   (data_ready),
        .parity_err   (parity_err),
        .framing_err  (framing_err),
        .overrun_err  (overrun_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!tick16);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [1:0] wl, input bit pe,
                              input bit ev, input bit st, input bit flip_par,
                              input bit bad_stop, input bit push);
        int   nbits;
        logic [7:0] m;
        logic pbit;
        exp_t e;
        nbits = 5 + int'(wl);
        m = d & ((8'd1 << nbits) - 8'd1);
        if (st) pbit = ~ev;
        else if (ev) pbit = ^m;
        else pbit = ~(^m);
        pbit = pbit ^ flip_par;
        cfg_wlen = wl; cfg_par_en = pe; cfg_par_even = ev; cfg_par_stick = st;
        e.data = m; e.perr = pe & flip_par; e.ferr = bad_stop;
        if (push) sb_q.push_back(e);
        rx_line = 1'b0; wait_ticks(16);
        for (int b = 0; b < nbits; b++) begin
            rx_line = d[b]; wait_ticks(16);
        end
        if (pe) begin rx_line = pbit; wait_ticks(16); end
        rx_line = ~bad_stop; wait_ticks(16);
        rx_line = 1'b1; wait_ticks(16);
    endtask

    // Monitor: pops the scoreboard whenever a character shows up, then reads it.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mon_en && data_ready && !mon_rd) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3 unexpected char", {24'd0, rx_data}, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rx_data == e.data, "R1/R2 data", {24'd0, rx_data}, {24'd0, e.data});
                    check(parity_err == e.perr, "R5/R6/R7 parity flag", {31'd0, parity_err}, {31'd0, e.perr});
                    check(framing_err == e.ferr, "R8 framing flag", {31'd0, framing_err}, {31'd0, e.ferr});
                    check(overrun_err == 1'b0, "R9 no overrun", {31'd0, overrun_err}, 32'd0);
                end
                mon_rd = 1'b1;
                @(negedge clk);
                mon_rd = 1'b0;
                check(data_ready == 1'b0, "R3 read clears ready", {31'd0, data_ready}, 32'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rx_data == 8'd0 && !data_ready, "R11 reset buffer", {23'd0, data_ready, rx_data}, 32'd0);
        check(!parity_err && !framing_err && !overrun_err, "R11 reset flags",
              {29'd0, parity_err, framing_err, overrun_err}, 32'd0);
        rst_n = 1'b1;
        wait_ticks(20);

        // R1 and R5: 8-bit words without parity
        send_frame(8'hA5, 2'b11, 0, 0, 0, 0, 0, 1);
        send_frame(8'h3C, 2'b11, 0, 0, 0, 0, 0, 1);
        // R1 and R2: shorter words, upper bits dropped
        send_frame(8'hFF, 2'b00, 0, 0, 0, 0, 0, 1);
        send_frame(8'hEA, 2'b01, 0, 0, 0, 0, 0, 1);
        send_frame(8'h81, 2'b10, 0, 0, 0, 0, 0, 1);
        // R6: even and odd parity, good and bad
        send_frame(8'h5B, 2'b11, 1, 1, 0, 0, 0, 1);
        send_frame(8'h5B, 2'b11, 1, 0, 0, 0, 0, 1);
        send_frame(8'h17, 2'b10, 1, 1, 0, 1, 0, 1);
        send_frame(8'h09, 2'b00, 1, 0, 0, 1, 0, 1);
        // R7: stick parity, both levels, good and bad
        send_frame(8'h44, 2'b11, 1, 0, 1, 0, 0, 1);
        send_frame(8'h44, 2'b11, 1, 0, 1, 1, 0, 1);
        send_frame(8'h2D, 2'b01, 1, 1, 1, 0, 0, 1);
        send_frame(8'h2D, 2'b01, 1, 1, 1, 1, 0, 1);
        // R8: bad stop bit still stores the character
        send_frame(8'hC3, 2'b11, 0, 0, 0, 0, 1, 1);
        // R10: a clean frame after an errored one has clear flags
        send_frame(8'h66, 2'b11, 1, 1, 0, 0, 0, 1);

        // R4: a low pulse shorter than half a bit is dropped
        rx_line = 1'b0; wait_ticks(4);
        rx_line = 1'b1; wait_ticks(40);
        check(data_ready == 1'b0, "R4 glitch ignored", {31'd0, data_ready}, 32'd0);
        send_frame(8'h71, 2'b11, 0, 0, 0, 0, 0, 1);
        wait_ticks(4);
        check(sb_q.size() == 0, "R4 frame after glitch received", sb_q.size(), 32'd0);

        // R9: two characters without a read in between
        mon_en = 1'b0;
        send_frame(8'h12, 2'b11, 1, 1, 0, 1, 0, 0);
        check(data_ready && rx_data == 8'h12 && !overrun_err, "R9 first char held",
              {22'd0, overrun_err, data_ready, rx_data}, {22'd0, 2'b01, 8'h12});
        check(parity_err == 1'b1, "R10 flag of first char", {31'd0, parity_err}, 32'd1);
        send_frame(8'h34, 2'b11, 0, 0, 0, 0, 0, 0);
        check(data_ready && rx_data == 8'h34, "R9 buffer overwritten",
              {23'd0, data_ready, rx_data}, {23'd0, 1'b1, 8'h34});
        check(overrun_err == 1'b1, "R9 overrun set", {31'd0, overrun_err}, 32'd1);
        check(parity_err == 1'b0, "R10 flag replaced on store", {31'd0, parity_err}, 32'd0);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        @(negedge clk);
        check(!data_ready && !overrun_err && !parity_err && !framing_err, "R10 read clears flags",
              {28'd0, data_ready, overrun_err, parity_err, framing_err}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule